// File: doc/BRIEF.md
# Serial Slave Receiver with High-True Select

This block is a three-wire serial slave. It has a select line, a serial clock and one data input, plus a return data output. Its select is active high. While the select is high, the block takes one data bit on each rising edge of the serial clock, most significant bit first. When the select drops, it counts the bits it took. A count of eight gives a short frame and a count of sixteen gives a long frame. Each is presented as a data word with a one-cycle valid strobe and a length flag. Any other count is reported through a one-cycle error strobe, and that frame is dropped.

All three serial inputs are slow compared with the system clock, so they are oversampled through synchronizer flops. Edges are then found from the synchronized levels. When the select rises, a caller-supplied word is loaded into a return shifter. One bit of that word leaves the block per frame bit, so the master can read a register value in the same frame.

Top module: `hsel_spi_slave`

## Requirements
- R1: After reset, `rx_valid_o`, `rx_err_o`, `rx_long_o`, `sdo_o` are 0 and `rx_word_o` is 0.
- R2: A frame of exactly 8 rising `sck_i` edges while `sel_i` is high yields `rx_word_o[7:0]` = the bits sampled on those edges, first bit in bit 7, with `rx_word_o[15:8]` = 0 and `rx_long_o` = 0.
- R3: A frame of exactly 16 rising edges yields `rx_word_o` = the sampled bits, first bit in bit 15, with `rx_long_o` = 1. `rx_valid_o` is high for exactly one system clock cycle per accepted frame.
- R4: A select window holding any count of rising edges other than 8 or 16 (including 0 and counts above 16) pulses `rx_err_o` for one cycle and does not pulse `rx_valid_o`.
- R5: A rejected frame leaves `rx_word_o` and `rx_long_o` at their previous values.
- R6: Serial clock and data activity while `sel_i` is low has no effect: no strobe appears, `rx_word_o` is unchanged, and the next frame is decoded as if that activity never happened.
- R7: `rx_valid_o` or `rx_err_o` becomes high at the third rising system clock edge after `sel_i` falls (synchronizer depth of 2 plus one output register).
- R8: When `sel_i` rises, `tx_word_i` is captured. `sdo_o` presents its bit 15 and moves to the next lower bit after each falling `sck_i` edge inside the window, so a master that reads `sdo_o` before each rising edge sees bits 15 downward.
- R9: `sdo_o` is 0 whenever the synchronized select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Frame select, high during a frame |
| sck_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data from the master |
| tx_word_i | input | 16 | Word returned to the master, captured at select rise |
| sdo_o | output | 1 | Serial data to the master |
| rx_word_o | output | 16 | Last accepted frame, short frames zero-extended |
| rx_valid_o | output | 1 | One-cycle strobe for an accepted frame |
| rx_long_o | output | 1 | 1 when the last accepted frame had 16 bits |
| rx_err_o | output | 1 | One-cycle strobe for a rejected frame |

## Verification
Each result lands a fixed number of system clock cycles after the serial event that causes it. A frame result lands three cycles after the select falls. A return bit lands three cycles after a serial clock fall or a select rise. The bench drives every input on a falling system clock edge and samples on falling edges as well. After the select drops, it counts falling edges until a strobe shows and requires that count to be exactly three. It then checks that the strobe is low one cycle later. Return bits are read half a serial period after each clock fall, well beyond their three-cycle delay. Ignored activity is judged from the outputs in the window before the next frame.

// File: rtl/hsel_pkg.sv
package hsel_pkg;
    parameter int unsigned LONG_BITS  = 16;
    parameter int unsigned SHORT_BITS = 8;
    parameter int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/hsel_sync.sv
module hsel_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= st_d[i];
        end
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/hsel_rx.sv
module hsel_rx #(
    parameter int unsigned LONG_W  = 16,
    parameter int unsigned SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sck,
    input  logic              sdi,
    output logic [LONG_W-1:0] word_o,
    output logic              valid_o,
    output logic              long_o,
    output logic              err_o
);
    localparam int unsigned CNT_W   = $clog2(LONG_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(LONG_W);
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(SHORT_W);

    typedef struct packed {
        logic              sel_p;
        logic              sck_p;
        logic [CNT_W-1:0]  cnt;
        logic [LONG_W-1:0] sh;
        logic [LONG_W-1:0] word;
        logic              long_f;
        logic              valid;
        logic              err;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        st_d.sel_p = sel;
        st_d.sck_p = sck;
        if (sel && !st_q.sel_p) begin
            st_d.cnt = '0;
            st_d.sh  = '0;
        end else if (sel && sck && !st_q.sck_p) begin
            st_d.sh = {st_q.sh[LONG_W-2:0], sdi};
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end else if (!sel && st_q.sel_p) begin
            if (st_q.cnt == CNT_LONG) begin
                st_d.word   = st_q.sh;
                st_d.long_f = 1'b1;
                st_d.valid  = 1'b1;
            end else if (st_q.cnt == CNT_SHORT) begin
                st_d.word                = '0;
                st_d.word[SHORT_W-1:0]   = st_q.sh[SHORT_W-1:0];
                st_d.long_f              = 1'b0;
                st_d.valid               = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign valid_o = st_q.valid;
    assign long_o  = st_q.long_f;
    assign err_o   = st_q.err;

    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.valid && st_q.err));
    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);
    assert_err_keeps_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> ($stable(st_q.word) && $stable(st_q.long_f)));
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !st_q.sel_p) |=> (st_q.cnt == '0));
    assert_idle_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !st_q.sel_p) |=> ($stable(st_q.cnt) && $stable(st_q.sh)));
endmodule

// File: rtl/hsel_tx.sv
module hsel_tx #(
    parameter int unsigned LONG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sck,
    input  logic [LONG_W-1:0] load_i,
    output logic              sdo_o
);
    typedef struct packed {
        logic              sel_p;
        logic              sck_p;
        logic [LONG_W-1:0] sh;
        logic              sdo;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   sck_fall;

    always_comb begin
        st_d       = st_q;
        st_d.sel_p = sel;
        st_d.sck_p = sck;
        sck_fall   = st_q.sck_p && !sck;
        if (sel && !st_q.sel_p)  st_d.sh = load_i;
        else if (sel && sck_fall) st_d.sh = {st_q.sh[LONG_W-2:0], 1'b0};
        st_d.sdo = sel ? st_d.sh[LONG_W-1] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_o = st_q.sdo;

    assert_shift_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && st_q.sel_p && !sck_fall) |=> $stable(st_q.sh));
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.sel_p && !sel) |=> !st_q.sdo);
endmodule

// File: rtl/hsel_spi_slave.sv
module hsel_spi_slave
    import hsel_pkg::*;
#(
    parameter int unsigned LONG_W  = LONG_BITS,
    parameter int unsigned SHORT_W = SHORT_BITS,
    parameter int unsigned SYNC_N  = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic [LONG_W-1:0] tx_word_i,
    output logic              sdo_o,
    output logic [LONG_W-1:0] rx_word_o,
    output logic              rx_valid_o,
    output logic              rx_long_o,
    output logic              rx_err_o
);
    logic [2:0] raw_w, syn_w;

    assign raw_w = {sel_i, sck_i, sdi_i};

    hsel_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_w), .q_o(syn_w)
    );

    hsel_rx #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .sel(syn_w[2]), .sck(syn_w[1]), .sdi(syn_w[0]),
        .word_o(rx_word_o), .valid_o(rx_valid_o),
        .long_o(rx_long_o), .err_o(rx_err_o)
    );

    hsel_tx #(.LONG_W(LONG_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .sel(syn_w[2]), .sck(syn_w[1]),
        .load_i(tx_word_i), .sdo_o(sdo_o)
    );
endmodule

// File: tb/tb_hsel_spi_slave.sv
module tb_hsel_spi_slave;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0, sck_i = 1'b0, sdi_i = 1'b0;
    logic [15:0] tx_word_i = '0;
    logic        sdo_o, rx_valid_o, rx_long_o, rx_err_o;
    logic [15:0] rx_word_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hsel_spi_slave dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sck_i(sck_i), .sdi_i(sdi_i),
        .tx_word_i(tx_word_i), .sdo_o(sdo_o), .rx_word_o(rx_word_o),
        .rx_valid_o(rx_valid_o), .rx_long_o(rx_long_o), .rx_err_o(rx_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Drives one select window with nb rising clock edges; checks return bits (R8).
    task automatic frame(input logic [31:0] bits, input int nb, input logic [15:0] txw,
                         input bit chk_sdo);
        tx_word_i = txw;
        sel_i = 1'b1;
        cyc(HALF);
        for (int i = 0; i < nb; i++) begin
            sdi_i = bits[nb-1-i];
            cyc(HALF);
            if (chk_sdo && i < 16) chk($sformatf("R8 bit%0d", i), 32'(sdo_o), 32'(txw[15-i]));
            sck_i = 1'b1;
            cyc(HALF);
            sck_i = 1'b0;
        end
        cyc(HALF);
        sel_i = 1'b0;
    endtask

    // Waits for a strobe after select fall; checks R7 latency and single-cycle pulse.
    task automatic wait_result(output bit got_v, output bit got_e);
        int k;
        k = 0; got_v = 0; got_e = 0;
        for (int j = 0; j < 20; j++) begin
            cyc(1); k++;
            if (rx_valid_o || rx_err_o) begin
                got_v = rx_valid_o; got_e = rx_err_o; break;
            end
        end
        chk("R7 latency", 32'(k), 32'd3);
        cyc(1);
        chk("R3 strobe width", 32'(rx_valid_o | rx_err_o), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(rx_valid_o), 0);
        chk("R1 err", 32'(rx_err_o), 0);
        chk("R1 long", 32'(rx_long_o), 0);
        chk("R1 word", 32'(rx_word_o), 0);
        chk("R1 sdo", 32'(sdo_o), 0);
    endtask

    task automatic t_short();
        bit v, e;
        frame(32'hA5, 8, 16'h3C00, 1);
        wait_result(v, e);
        chk("R2 valid", 32'(v), 1);
        chk("R2 word", 32'(rx_word_o), 32'h00A5);
        chk("R2 long", 32'(rx_long_o), 0);
        cyc(4);
        chk("R9 sdo idle", 32'(sdo_o), 0);
    endtask

    task automatic t_long();
        bit v, e;
        frame(32'hBEEF, 16, 16'h1234, 1);
        wait_result(v, e);
        chk("R3 valid", 32'(v), 1);
        chk("R3 err", 32'(e), 0);
        chk("R3 word", 32'(rx_word_o), 32'hBEEF);
        chk("R3 long", 32'(rx_long_o), 1);
    endtask

    task automatic t_bad(input int nb);
        bit v, e;
        frame(32'h0ABC1, nb, 16'hFFFF, 0);
        wait_result(v, e);
        chk($sformatf("R4 err n=%0d", nb), 32'(e), 1);
        chk($sformatf("R4 novalid n=%0d", nb), 32'(v), 0);
        chk("R5 word kept", 32'(rx_word_o), 32'hBEEF);
        chk("R5 long kept", 32'(rx_long_o), 1);
    endtask

    task automatic t_idle_noise();
        bit v, e, seen;
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            sdi_i = i[0];
            sck_i = 1'b1;
            for (int j = 0; j < HALF; j++) begin cyc(1); seen |= rx_valid_o | rx_err_o; end
            sck_i = 1'b0;
            for (int j = 0; j < HALF; j++) begin cyc(1); seen |= rx_valid_o | rx_err_o; end
        end
        cyc(6);
        chk("R6 no strobe", 32'(seen | rx_valid_o | rx_err_o), 0);
        chk("R6 word kept", 32'(rx_word_o), 32'hBEEF);
        chk("R9 sdo idle", 32'(sdo_o), 0);
        frame(32'h5A, 8, 16'hC300, 1);
        wait_result(v, e);
        chk("R6 next frame valid", 32'(v), 1);
        chk("R6 next frame word", 32'(rx_word_o), 32'h005A);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_short();
        t_long();
        t_bad(12);
        t_bad(0);
        t_bad(20);
        t_idle_noise();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule